// File: doc/BRIEF.md
# Trap and Subroutine Next-PC Unit

This block works out where control goes after a control-transfer instruction in a 16-bit processor. It also produces the return address that must be saved. It decodes three instruction families. The first is the subroutine call, in a PC-relative or a register-target form. The second is the register jump, which also serves as subroutine return when its base register is R7. The third is the system call, which reaches its handler through a table in low memory.

The pipeline supplies four values: the instruction word, the already incremented PC, the value of the base register that the instruction names, and the word that memory returns from the handler table. The block answers with a PC-load strobe and the new PC. It also gives a write enable for the link register R7, with the value to store there.

A system call takes two cycles. In the first cycle the block issues the zero-extended table address and saves the return address. In the second cycle it loads the table word into the PC. A busy flag marks the second cycle, and during that cycle new instructions are not accepted.

Top module: `ctl_xfer_npc`

## Requirements
- R1: A call with opcode bits[15:12]=0100 and bit 11 = 1 asserts pc_load in the same cycle, with pc_next = pc_inc + sign-extended instr[10:0].
- R2: A call with opcode 0100 and bit 11 = 0 asserts pc_load in the same cycle, with pc_next = base_val.
- R3: Both call forms assert link_we with link_val = pc_inc in the same cycle. The register form takes its target from base_val as presented in that cycle, so a base of R7 jumps to the old R7 and not to the new link value.
- R4: A jump with opcode 1100 (including return through R7) asserts pc_load with pc_next = base_val and keeps link_we low.
- R5: In its first cycle, a system call with opcode 1111 asserts vec_rd, with vec_addr = {8'h00, instr[7:0]}. It also asserts link_we with link_val = pc_inc, and keeps pc_load low.
- R6: In the cycle after a system call's first cycle, busy is high and pc_load is high with pc_next = tbl_word. link_we and vec_rd are both low in that cycle.
- R7: busy lasts exactly one cycle. While busy is high, the instruction inputs are ignored: no link write and no table read.
- R8: With instr_vld low, or with any other opcode, pc_load, link_we and vec_rd all stay low.
- R9: After reset, busy is low and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the following instruction |
| base_val | input | 16 | Contents of the register named by instr[8:6] |
| tbl_word | input | 16 | Handler address read from the table |
| pc_load | output | 1 | Load pc_next into the PC |
| pc_next | output | 16 | New PC value |
| link_we | output | 1 | Write link_val into R7 |
| link_val | output | 16 | Return address |
| vec_rd | output | 1 | Table read request |
| vec_addr | output | 16 | Table address |
| busy | output | 1 | Second cycle of a system call |

## Verification
The PC-relative call is tried with positive, negative, most-negative and most-positive offsets, and with a sum that wraps past xFFFF. These cases separate correct sign extension of bit 10 from zero extension and from truncation. The register call and the jump are given a base value that differs from pc_inc, which exposes any swap between target and link. A register call through R7 shows that the target comes from the old register contents. System calls with vectors x00, x25 and xFF check that the upper address byte stays zero. A second instruction presented during the busy cycle shows whether the input gate is working. Opcodes that neighbour the decoded ones, and a valid-low strobe, check that no action leaks through.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int XW   = 16;
  localparam int OPW  = 4;
  localparam logic [OPW-1:0] OP_CALL = 4'b0100;
  localparam logic [OPW-1:0] OP_JUMP = 4'b1100;
  localparam logic [OPW-1:0] OP_SYSC = 4'b1111;

  typedef enum logic [1:0] {
    XK_NONE = 2'd0,
    XK_CALL = 2'd1,
    XK_JUMP = 2'd2,
    XK_SYSC = 2'd3
  } xfer_kind_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic             vld,
  input  logic             hold,
  input  logic [OPW-1:0]   opcode,
  output xfer_kind_t       kind
);
  always_comb begin
    kind = XK_NONE;
    if (vld && !hold) begin
      unique case (opcode)
        OP_CALL: kind = XK_CALL;
        OP_JUMP: kind = XK_JUMP;
        OP_SYSC: kind = XK_SYSC;
        default: kind = XK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int W    = XW,
  parameter int OFFW = 11
) (
  input  xfer_kind_t    kind,
  input  logic          rel_mode,
  input  logic [OFFW-1:0] offset,
  input  logic [W-1:0]  pc_inc,
  input  logic [W-1:0]  base_val,
  output logic [W-1:0]  target,
  output logic          rel_used
);
  localparam int EXTW = W - OFFW;

  function automatic logic [W-1:0] rel_target(input logic [W-1:0] pc,
                                              input logic [OFFW-1:0] off);
    rel_target = pc + {{EXTW{off[OFFW-1]}}, off};
  endfunction

  assign rel_used = (kind == XK_CALL) && rel_mode;
  assign target   = rel_used ? rel_target(pc_inc, offset) : base_val;
endmodule

// File: rtl/trap_seq.sv
module trap_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= fire;
  end

  p_fire_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);
  p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/ctl_xfer_npc.sv
module ctl_xfer_npc
  import xfer_pkg::*;
#(
  parameter int W    = XW,
  parameter int OFFW = 11,
  parameter int VECW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_vld,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] tbl_word,
  output logic         pc_load,
  output logic [W-1:0] pc_next,
  output logic         link_we,
  output logic [W-1:0] link_val,
  output logic         vec_rd,
  output logic [W-1:0] vec_addr,
  output logic         busy
);
  localparam int OPLSB = W - OPW;
  localparam int MODEB = OFFW;

  function automatic logic [W-1:0] zext_vec(input logic [VECW-1:0] v);
    zext_vec = {{(W-VECW){1'b0}}, v};
  endfunction

  xfer_kind_t   kind;
  logic [W-1:0] tgt;
  logic         rel_used;
  logic         sysc_fire;
  logic         call_hit;
  logic         jump_hit;

  xfer_decode u_dec (
    .vld    (instr_vld),
    .hold   (busy),
    .opcode (instr[W-1:OPLSB]),
    .kind   (kind)
  );

  xfer_target #(.W(W), .OFFW(OFFW)) u_tgt (
    .kind     (kind),
    .rel_mode (instr[MODEB]),
    .offset   (instr[OFFW-1:0]),
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .target   (tgt),
    .rel_used (rel_used)
  );

  assign sysc_fire = (kind == XK_SYSC);
  assign call_hit  = (kind == XK_CALL);
  assign jump_hit  = (kind == XK_JUMP);

  trap_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (sysc_fire),
    .busy  (busy)
  );

  assign pc_load  = call_hit || jump_hit || busy;
  assign pc_next  = busy ? tbl_word : tgt;
  assign link_we  = call_hit || sysc_fire;
  assign link_val = pc_inc;
  assign vec_rd   = sysc_fire;
  assign vec_addr = zext_vec(instr[VECW-1:0]);

  p_jump_nolink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jump_hit |-> (pc_load && !link_we));
  p_sysc_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (!pc_load && link_we && vec_addr[W-1:VECW] == '0));
  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc_load && !link_we && !vec_rd));
  p_rel_only_call_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rel_used |-> (link_we && pc_load));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_vld && !busy) |-> !(pc_load || link_we || vec_rd));
endmodule

// File: tb/tb_ctl_xfer_npc.sv
module tb_ctl_xfer_npc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_vld = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, tbl_word = '0;
  logic        pc_load, link_we, vec_rd, busy;
  logic [15:0] pc_next, link_val, vec_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ctl_xfer_npc dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_rel(input logic [10:0] off);
    return {4'b0100, 1'b1, off};
  endfunction
  function automatic logic [15:0] mk_reg(input logic [3:0] op, input logic [2:0] r);
    return {op, 3'b000, r, 6'b000000};
  endfunction

  task automatic idle();
    @(negedge clk);
    instr_vld = 1'b0; instr = 16'h0000;
  endtask

  task automatic t_reset();
    #1;
    chk("R9", "busy", {15'd0, busy}, 16'd0);
    chk("R9", "strobes", {13'd0, pc_load, link_we, vec_rd}, 16'd0);
  endtask

  task automatic t_rel(input logic [10:0] off, input logic [15:0] pc);
    logic [15:0] sx;
    @(negedge clk);
    sx = off[10] ? (16'hF800 | 16'(off)) : 16'(off);
    instr_vld = 1'b1; instr = mk_rel(off); pc_inc = pc; base_val = 16'hDEAD;
    #2;
    chk("R1", "pc_load", {15'd0, pc_load}, 16'd1);
    chk("R1", "pc_next", pc_next, pc + sx);
    chk("R3", "link_we", {15'd0, link_we}, 16'd1);
    chk("R3", "link_val", link_val, pc);
    idle();
  endtask

  task automatic t_jsrr(input logic [2:0] r, input logic [15:0] pc, input logic [15:0] b);
    @(negedge clk);
    instr_vld = 1'b1; instr = mk_reg(4'b0100, r); pc_inc = pc; base_val = b;
    #2;
    chk("R2", "pc_load", {15'd0, pc_load}, 16'd1);
    chk("R2", "pc_next", pc_next, b);
    chk("R3", "link_val", link_val, pc);
    chk("R3", "link_we", {15'd0, link_we}, 16'd1);
    idle();
  endtask

  task automatic t_jmp(input logic [2:0] r, input logic [15:0] b);
    @(negedge clk);
    instr_vld = 1'b1; instr = mk_reg(4'b1100, r); pc_inc = 16'h3001; base_val = b;
    #2;
    chk("R4", "pc_load", {15'd0, pc_load}, 16'd1);
    chk("R4", "pc_next", pc_next, b);
    chk("R4", "link_we", {15'd0, link_we}, 16'd0);
    idle();
  endtask

  task automatic t_trap(input logic [7:0] v, input logic [15:0] pc, input logic [15:0] w,
                        input bit intrude);
    @(negedge clk);
    instr_vld = 1'b1; instr = {8'hF0, v}; pc_inc = pc; tbl_word = w;
    #2;
    chk("R5", "vec_rd", {15'd0, vec_rd}, 16'd1);
    chk("R5", "vec_addr", vec_addr, {8'h00, v});
    chk("R5", "link_we", {15'd0, link_we}, 16'd1);
    chk("R5", "link_val", link_val, pc);
    chk("R5", "pc_load", {15'd0, pc_load}, 16'd0);
    @(negedge clk);
    if (intrude) begin
      instr = {8'hF0, 8'h77};
      pc_inc = 16'h9999;
    end else begin
      instr_vld = 1'b0;
    end
    #2;
    chk("R6", "busy", {15'd0, busy}, 16'd1);
    chk("R6", "pc_load", {15'd0, pc_load}, 16'd1);
    chk("R6", "pc_next", pc_next, w);
    chk("R7", "link_we", {15'd0, link_we}, 16'd0);
    chk("R7", "vec_rd", {15'd0, vec_rd}, 16'd0);
    idle();
    #2;
    chk("R7", "busy", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_other(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr_vld = v; instr = w; pc_inc = 16'h1234; base_val = 16'h4321;
    #2;
    chk("R8", "strobes", {13'd0, pc_load, link_we, vec_rd}, 16'd0);
    idle();
  endtask

  initial begin
    fork
      begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rel(11'h010, 16'h3002);
    t_rel(11'h7FC, 16'h3010);
    t_rel(11'h400, 16'h3000);
    t_rel(11'h3FF, 16'hFF00);
    t_jsrr(3'd4, 16'h3005, 16'h5000);
    t_jsrr(3'd7, 16'h3100, 16'h0A0A);
    t_jmp(3'd2, 16'h4444);
    t_jmp(3'd7, 16'h3021);
    t_trap(8'h25, 16'h3008, 16'hFD70, 1'b0);
    t_trap(8'h00, 16'h3009, 16'h0400, 1'b1);
    t_trap(8'hFF, 16'h300A, 16'h0520, 1'b0);
    t_other(16'h1261, 1'b1);
    t_other(16'h0E05, 1'b1);
    t_other(16'hE001, 1'b1);
    t_other(mk_rel(11'h005), 1'b0);
    t_other({8'hF0, 8'h21}, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule